// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block is the watchdog of a small microcontroller core. An up-counter of `CNT_W` bits advances once for every enabled clock cycle, either directly or through a shared prescaler that divides the enabled cycles by a power of two. When the counter rolls over from all-ones to zero, the block raises a one-cycle time-out pulse. The surrounding chip uses that pulse to reset the core, or to wake it when it sleeps.

Two status bits record why the core last restarted. The time-out bit is set when software services the watchdog or enters sleep, and it is cleared by a time-out. The power-down bit is set when software services the watchdog and cleared when software enters sleep. A clear strobe from the instruction decoder restarts the counter and the prescaler count. It leaves the ratio select alone. A sleep strobe also restarts both counts.

The two flags come from a four-state machine:
- `ST_AWAKE`: time-out bit 1, power-down bit 1.
- `ST_NAPPING`: time-out bit 1, power-down bit 0.
- `ST_BARKED`: time-out bit 0, power-down bit 1.
- `ST_BARKED_NAP`: time-out bit 0, power-down bit 0.

The transitions, in priority order, are:
- `T_SERVICE` (clear strobe): any state goes to `ST_AWAKE`.
- `T_DOZE` (sleep strobe without clear): any state goes to `ST_NAPPING`.
- `T_BITE_RUN` (overflow): `ST_AWAKE` goes to `ST_BARKED`.
- `T_BITE_NAP` (overflow): `ST_NAPPING` goes to `ST_BARKED_NAP`.
- `T_HOLD`: all other cases; the barked states stay where they are.

Top module: `wdt_timer`

## Requirements
- R1: After reset is released, `to_flag` and `pd_flag` are 1 and `wdt_bark` is 0. With the prescaler not assigned and `run_en` held high, the first pulse comes after exactly 256 clock edges.
- R2: When `pre_to_wdt` is 0, the counter advances on every enabled edge. Time-out pulses repeat every 256 enabled edges.
- R3: When `pre_to_wdt` is 1, the period is 256 × 2^(`ratio_sel`+1) enabled edges, for `ratio_sel` from 0 to 7.
- R4: A `clr_wdt` strobe zeroes the counter and the prescaler count. The next pulse comes exactly one full period after the strobe edge, however far the count had run, and the ratio select is unchanged.
- R5: After a `clr_wdt` edge, `to_flag` and `pd_flag` are both 1.
- R6: `wdt_bark` is high for exactly one cycle per time-out. On that edge `to_flag` becomes 0 and `pd_flag` keeps its value.
- R7: A `sleep_req` strobe without a clear makes `pd_flag` 0 and `to_flag` 1, and restarts the period. A later time-out leaves both flags at 0.
- R8: A `clr_wdt` strobe on the edge that would overflow suppresses the pulse and leaves `to_flag` at 1.
- R9: While `run_en` is 0, neither count advances and no pulse is produced. Counting resumes where it stopped.
- R10: When `clr_wdt` and `sleep_req` come on the same edge, the clear wins and both flags are 1.
- R11: A `sleep_req` strobe on the edge that would overflow suppresses the pulse. The flags become `pd_flag`=0 and `to_flag`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-up reset |
| run_en | input | 1 | Count enable; one enabled edge is one watchdog tick |
| pre_to_wdt | input | 1 | 1 = prescaler divides the ticks, 0 = no division |
| ratio_sel | input | 3 | Prescaler ratio select; divide by 2^(sel+1) |
| clr_wdt | input | 1 | Clear strobe from the instruction decoder |
| sleep_req | input | 1 | Sleep-entry strobe |
| wdt_bark | output | 1 | One-cycle time-out pulse for reset or wake |
| to_flag | output | 1 | Time-out status bit |
| pd_flag | output | 1 | Power-down status bit |

## Verification
The clear or sleep strobe can land on the same edge as the counter's roll-over. The clear and sleep strobes can also arrive together. The bench clears the watchdog and steps exactly 255 enabled edges, which puts the counter at all-ones. It then raises the strobe for the next edge. The bench then requires that no pulse appears and that the flags take the strobe's values. It also requires that the next time-out comes a full 256 edges later. For the strobe pair, the flags must show the clear's values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Status flag machine: encodes {time-out, power-down}
    typedef enum logic [1:0] {
        ST_BARKED_NAP = 2'b00,
        ST_BARKED     = 2'b01,
        ST_NAPPING    = 2'b10,
        ST_AWAKE      = 2'b11
    } wdt_state_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             assigned,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             restart,
    output logic             tick_o
);
    localparam int PS_W = 1 << SEL_W;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;
    logic            wrap;

    // mask has ratio_sel+1 low ones: divide by 2^(sel+1)
    for (genvar g = 0; g < PS_W; g++) begin : g_mask
        assign mask[g] = (ratio_sel >= SEL_W'(g));
    end

    assign wrap   = ((ps_q & mask) == mask);
    assign tick_o = run_en & (assigned ? wrap : 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (restart) begin
            ps_q <= '0;
        end else if (run_en && assigned) begin
            ps_q <= wrap ? '0 : ps_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic ovf_o,
    output logic bark_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             bark_q;

    // a restart on the roll-over edge wins over the time-out
    assign ovf_o = tick & (cnt_q == TOP) & ~restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bark_q <= 1'b0;
        else        bark_q <= ovf_o;
    end

    assign bark_o = bark_q;
endmodule

// File: rtl/wdt_status_fsm.sv
module wdt_status_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic service,
    input  logic doze,
    input  logic bite,
    output logic to_o,
    output logic pd_o
);
    wdt_state_e state_q, state_d;

    // next state: T_SERVICE > T_DOZE > T_BITE_* > T_HOLD
    always_comb begin
        state_d = state_q;
        if (service) begin
            state_d = ST_AWAKE;
        end else if (doze) begin
            state_d = ST_NAPPING;
        end else if (bite) begin
            unique case (state_q)
                ST_AWAKE:      state_d = ST_BARKED;
                ST_NAPPING:    state_d = ST_BARKED_NAP;
                ST_BARKED:     state_d = ST_BARKED;
                ST_BARKED_NAP: state_d = ST_BARKED_NAP;
                default:       state_d = ST_AWAKE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_AWAKE:      begin to_o = 1'b1; pd_o = 1'b1; end
            ST_NAPPING:    begin to_o = 1'b1; pd_o = 1'b0; end
            ST_BARKED:     begin to_o = 1'b0; pd_o = 1'b1; end
            ST_BARKED_NAP: begin to_o = 1'b0; pd_o = 1'b0; end
            default:       begin to_o = 1'b1; pd_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             pre_to_wdt,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             clr_wdt,
    input  logic             sleep_req,
    output logic             wdt_bark,
    output logic             to_flag,
    output logic             pd_flag
);
    logic restart;
    logic tick;
    logic ovf;

    assign restart = clr_wdt | sleep_req;

    wdt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .assigned  (pre_to_wdt),
        .ratio_sel (ratio_sel),
        .restart   (restart),
        .tick_o    (tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .ovf_o   (ovf),
        .bark_o  (wdt_bark)
    );

    wdt_status_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .service (clr_wdt),
        .doze    (sleep_req),
        .bite    (ovf),
        .to_o    (to_flag),
        .pd_o    (pd_flag)
    );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic clr_wdt,
    input logic sleep_req,
    input logic wdt_bark,
    input logic to_flag,
    input logic pd_flag
);
    // R6: the pulse lasts one cycle
    p_one_cycle_bark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_bark |=> !wdt_bark);

    // R6: the pulse comes with a cleared time-out bit
    p_bark_clears_to_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_bark |-> !to_flag);

    // R6: the power-down bit is kept on a time-out
    p_bark_keeps_pd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_bark) |-> $stable(pd_flag));

    // R5 and R10: a clear sets both flags
    p_clear_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wdt |=> (to_flag && pd_flag));

    // R8: a clear suppresses any pulse
    p_clear_no_bark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wdt |=> !wdt_bark);

    // R7 and R11: sleep without a clear gives TO=1, PD=0 and no pulse
    p_sleep_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !clr_wdt) |=> (to_flag && !pd_flag && !wdt_bark));

    // R9: no pulse when the count is held
    p_hold_no_bark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clr_wdt && !sleep_req) |=> !wdt_bark);
endmodule

bind wdt_timer wdt_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .clr_wdt   (clr_wdt),
    .sleep_req (sleep_req),
    .wdt_bark  (wdt_bark),
    .to_flag   (to_flag),
    .pd_flag   (pd_flag)
);

// File: tb/sim_wdt_timer.sv
`timescale 1ns/1ps
module sim_wdt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       pre_to_wdt = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic       clr_wdt = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wdt_bark;
    logic       to_flag;
    logic       pd_flag;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    wdt_timer u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_to_wdt(pre_to_wdt),
        .ratio_sel(ratio_sel), .clr_wdt(clr_wdt), .sleep_req(sleep_req),
        .wdt_bark(wdt_bark), .to_flag(to_flag), .pd_flag(pd_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // count edges until the pulse is seen at a falling edge
    task automatic measure(input string tag, input int exp);
        int n = 0;
        while (n < exp + 64) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (wdt_bark) break;
        end
        check(tag, n, exp);
    endtask

    task automatic strobe(input logic c, input logic s);
        clr_wdt = c; sleep_req = s;
        @(posedge clk); @(negedge clk);
        clr_wdt = 1'b0; sleep_req = 1'b0;
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 195000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: reset state
        check("R1 to", to_flag, 1);
        check("R1 pd", pd_flag, 1);
        check("R1 bark", wdt_bark, 0);
        rst_n = 1'b1; run_en = 1'b1;
        measure("R1 first period", 256);
        check("R6 to on bark", to_flag, 0);
        check("R6 pd on bark", pd_flag, 1);
        step(1);
        check("R6 one cycle", wdt_bark, 0);
        measure("R2 free-run period", 255);  // one edge already stepped

        strobe(1'b1, 1'b0);
        check("R5 to", to_flag, 1);
        check("R5 pd", pd_flag, 1);
        measure("R2 after clear", 256);

        // R3 and R4: sweep every ratio
        pre_to_wdt = 1'b1;
        for (int s = 0; s < 8; s++) begin
            ratio_sel = 3'(s);
            strobe(1'b1, 1'b0);
            measure($sformatf("R3 sel %0d", s), 256 << (s + 1));
        end
        // R4: mid-count clear with a ratio of 4 restarts the prescaler too
        ratio_sel = 3'd1;
        strobe(1'b1, 1'b0);
        step(1001);
        strobe(1'b1, 1'b0);
        measure("R4 mid-count clear sel 1", 1024);
        pre_to_wdt = 1'b0;
        strobe(1'b1, 1'b0);
        step(100);
        strobe(1'b1, 1'b0);
        measure("R4 mid-count clear", 256);

        // R9: hold
        strobe(1'b1, 1'b0);
        step(200);
        run_en = 1'b0;
        step(80);
        check("R9 no bark held", wdt_bark, 0);
        run_en = 1'b1;
        measure("R9 resume", 56);

        // R8: clear on the overflow edge
        strobe(1'b1, 1'b0);
        step(255);
        strobe(1'b1, 1'b0);
        check("R8 no bark", wdt_bark, 0);
        check("R8 to kept", to_flag, 1);
        measure("R8 next period", 256);

        // R7: sleep, then time-out while asleep
        strobe(1'b0, 1'b1);
        check("R7 pd", pd_flag, 0);
        check("R7 to", to_flag, 1);
        measure("R7 period", 256);
        check("R7 wake to", to_flag, 0);
        check("R7 wake pd", pd_flag, 0);
        strobe(1'b1, 1'b0);
        check("R5 after wake to", to_flag, 1);
        check("R5 after wake pd", pd_flag, 1);

        // R11: sleep on the overflow edge
        step(255);
        strobe(1'b0, 1'b1);
        check("R11 no bark", wdt_bark, 0);
        check("R11 pd", pd_flag, 0);
        check("R11 to", to_flag, 1);
        measure("R11 next period", 256);

        // R10: clear and sleep together
        strobe(1'b1, 1'b1);
        check("R10 to", to_flag, 1);
        check("R10 pd", pd_flag, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule